// File: doc/BRIEF.md
# Dual-Channel Buffered Pulse Width Modulator

Two pulse width modulator channels sit behind a small register bus. Each channel keeps a duty value and a polarity bit in buffer registers. A write lands in the buffer, and the block copies it to the active register only at a point where the output cannot glitch. The counter of each channel runs for a period of (field+1)×16 clocks, where the 4-bit field comes from a shared period register. The output is at its active level while the counter is below the active duty value, and the polarity bit inverts it.

Each duty register can be written through two addresses. The plain address defers the value to the end of the running cycle, or applies it at once when the channel's update-immediate bit is set. The second address holds the value back until the channel's control register has also been read or written. The value then moves at the end of that cycle, together with any new polarity. This lets software switch to a constant-high output with no glitch by writing duty 0 and then flipping the polarity. When both period fields are equal, the two channels run in lockstep, and all transfers wait for a boundary that both channels share. A preset command restarts both counters in phase.

Each channel is controlled by a four-state machine. The states are CH_IDLE (nothing pending), CH_DIRECT (a plain-address value is waiting for the cycle end), CH_ILK_WAIT (a held value is waiting for a control access) and CH_ILK_ARMED (a control access has happened and the transfer is due at the cycle end). The transitions are as follows:
- A plain write goes to CH_DIRECT, or to CH_IDLE when it is applied at once.
- A held write goes to CH_ILK_WAIT.
- A control access moves CH_ILK_WAIT to CH_ILK_ARMED. If that access falls in the last clock of a period, it goes straight to CH_IDLE.
- A transfer moves CH_DIRECT and CH_ILK_ARMED back to CH_IDLE.

Top module: `pwm_dual`

## Requirements
- R1: The register map is as follows. 0x10 and 0x11 are the plain and held duty addresses of channel A, and 0x12 and 0x13 are those of channel B. 0x14 and 0x15 are the control registers of A and B: bit0 is polarity, bit1 is update-immediate, and bit7 is a read-only pending flag. 0x16 is the period register, with bits 3:0 for A and bits 7:4 for B, and it reads back the written value. A write of any value to 0x17 is the preset command.
- R2: A read of either duty address of a channel returns that channel's active duty. A write to either address goes only to the buffer, so reads keep showing the old value until the transfer.
- R3: A value written to the held address stays out of the active register until a cycle end in a cycle where the channel's control register was read or written. A control access in the very last clock of a period transfers at that same boundary. Bit7 of the control register reads 1 while such a value is pending.
- R4: A plain-address write becomes active at the end of the running cycle when bit1 of control is 0, and on the next clock when bit1 is 1.
- R5: A written period field takes effect only after the running cycle completes. The cycle in progress keeps its length, and each later cycle lasts (field+1)×16 clocks.
- R6: When the two active period fields differ, a channel's update-immediate bit and transfers work without regard to the other channel's pending state.
- R7: When the two active period fields are equal, transfers happen only at a boundary shared by both channels, and only while neither channel has a held value waiting for its control access. The update-immediate bit is then ignored.
- R8: Over any full period of L clocks, the output is high for min(duty, L) clocks with polarity 0, and for L−min(duty, L) clocks with polarity 1.
- R9: Preset restarts both counters at 0 in the same clock and loads the buffered period fields. With equal periods and duties, the two outputs are then identical.
- R10: Reset clears all buffer and active registers, counters and pending flags, and holds both outputs low.
- R11: A new polarity value becomes active only at a cycle end. When it is written through a held-duty arm, it moves in the same clock as the duty. Duty 0 with a polarity flip then gives a constant-high output with no low pulse left over from an early switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same clock as bus_rd |
| pwm_a | output | 1 | Channel A output |
| pwm_b | output | 1 | Channel B output |

## Verification
The sharpest coincidence is a control-register access that arms a held duty value in the same clock that ends a period, so that arming and transfer fall in one cycle. The bench aligns the counters with a preset and counts exactly fifteen clocks on a 16-clock period. It then reads the control register and expects the new duty value at the very next duty read. A design that waits one more period for the arm fails that read. A second coincidence is a polarity write that arrives together with the transfer. It is judged by counting falling edges in the output across the switch to constant high.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int ADDR_W = 8;
    localparam int BUS_W  = 8;
    localparam int PER_W  = 4;
    localparam int SUB_W  = 4;
    localparam int DUTY_W = PER_W + SUB_W;
    localparam int NCH    = 2;

    localparam logic [ADDR_W-1:0] REG_BASE   = 8'h10;
    localparam logic [ADDR_W-1:0] REG_CTL0   = REG_BASE + 8'd4;
    localparam logic [ADDR_W-1:0] REG_PERIOD = REG_BASE + 8'd6;
    localparam logic [ADDR_W-1:0] REG_PRESET = REG_BASE + 8'd7;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_DIRECT,
        CH_ILK_WAIT,
        CH_ILK_ARMED
    } chan_st_e;
endpackage

// File: rtl/pwm_regif.sv
module pwm_regif
    import pwm_pkg::*;
(
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        wr,
    input  logic                        rd,
    input  logic [NCH-1:0][DUTY_W-1:0]  duty_act,
    input  logic [NCH-1:0][BUS_W-1:0]   ctl_val,
    input  logic [BUS_W-1:0]            per_val,
    output logic [NCH-1:0]              duty_wr,
    output logic                        duty_held,
    output logic [NCH-1:0]              ctl_wr,
    output logic [NCH-1:0]              ctl_acc,
    output logic                        per_wr,
    output logic                        preset,
    output logic [BUS_W-1:0]            rdata
);
    logic [NCH-1:0] hit_duty;
    logic [NCH-1:0] hit_ctl;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
        localparam logic [ADDR_W-1:0] PLAIN = REG_BASE + ADDR_W'(2 * ch);
        localparam logic [ADDR_W-1:0] CTL   = REG_CTL0 + ADDR_W'(ch);
        assign hit_duty[ch] = (addr == PLAIN) || (addr == PLAIN + 8'd1);
        assign hit_ctl[ch]  = (addr == CTL);
        assign duty_wr[ch]  = wr && hit_duty[ch];
        assign ctl_wr[ch]   = wr && hit_ctl[ch];
        assign ctl_acc[ch]  = (wr || rd) && hit_ctl[ch];
    end

    assign duty_held = addr[0];
    assign per_wr    = wr && (addr == REG_PERIOD);
    assign preset    = wr && (addr == REG_PRESET);

    always_comb begin
        rdata = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (hit_duty[ch]) rdata = duty_act[ch];
            if (hit_ctl[ch])  rdata = ctl_val[ch];
        end
        if (addr == REG_PERIOD) rdata = per_val;
    end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
#(
    parameter int PW = PER_W,
    parameter int SW = SUB_W,
    parameter int BW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          duty_wr,
    input  logic          duty_held,
    input  logic          ctl_wr,
    input  logic          ctl_acc,
    input  logic [BW-1:0] wdata,
    input  logic          per_wr,
    input  logic [PW-1:0] per_wdata,
    input  logic          preset,
    input  logic          lock,
    input  logic          peer_end,
    input  logic          peer_wait,
    output logic          end_o,
    output logic          wait_o,
    output logic [PW+SW-1:0] duty_act_o,
    output logic [BW-1:0] ctl_val_o,
    output logic [PW-1:0] per_buf_o,
    output logic [PW-1:0] per_act_o,
    output logic          pwm_o
);
    localparam int CW = PW + SW;

    chan_st_e st_q, st_d;
    logic [CW-1:0] cnt_q, duty_buf_q, duty_act_q;
    logic [PW-1:0] per_buf_q, per_act_q;
    logic          pol_buf_q, pol_act_q, upd_q, pwm_q;
    logic          cyc_end, armed_now, boundary, xfer_duty, xfer_pol, imm;

    assign cyc_end   = (cnt_q == {per_act_q, {SW{1'b1}}});
    assign armed_now = (st_q == CH_ILK_ARMED) || ((st_q == CH_ILK_WAIT) && ctl_acc);
    assign wait_o    = (st_q == CH_ILK_WAIT) && !ctl_acc;
    assign end_o     = cyc_end;
    assign boundary  = lock ? (cyc_end && peer_end && !wait_o && !peer_wait) : cyc_end;
    assign xfer_duty = boundary && ((st_q == CH_DIRECT) || armed_now);
    assign xfer_pol  = boundary && !wait_o;
    assign imm       = duty_wr && !duty_held && upd_q && !lock;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (duty_wr) begin
            if (duty_held) st_d = CH_ILK_WAIT;
            else if (imm)  st_d = CH_IDLE;
            else           st_d = CH_DIRECT;
        end else begin
            unique case (st_q)
                CH_IDLE:      st_d = CH_IDLE;
                CH_DIRECT:    if (xfer_duty) st_d = CH_IDLE;
                CH_ILK_WAIT:  if (ctl_acc) st_d = xfer_duty ? CH_IDLE : CH_ILK_ARMED;
                CH_ILK_ARMED: if (xfer_duty) st_d = CH_IDLE;
                default:      st_d = CH_IDLE;
            endcase
        end
    end

    // data registers and output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            duty_buf_q <= '0;
            duty_act_q <= '0;
            per_buf_q  <= '0;
            per_act_q  <= '0;
            pol_buf_q  <= 1'b0;
            pol_act_q  <= 1'b0;
            upd_q      <= 1'b0;
            pwm_q      <= 1'b0;
        end else begin
            if (preset || cyc_end) begin
                cnt_q     <= '0;
                per_act_q <= per_wr ? per_wdata : per_buf_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (per_wr)  per_buf_q  <= per_wdata;
            if (duty_wr) duty_buf_q <= wdata[CW-1:0];
            if (imm)            duty_act_q <= wdata[CW-1:0];
            else if (xfer_duty) duty_act_q <= duty_buf_q;
            if (ctl_wr) begin
                pol_buf_q <= wdata[0];
                upd_q     <= wdata[1];
            end
            if (xfer_pol) pol_act_q <= ctl_wr ? wdata[0] : pol_buf_q;
            pwm_q <= (cnt_q < duty_act_q) ^ pol_act_q;
        end
    end

    always_comb begin
        ctl_val_o       = '0;
        ctl_val_o[0]    = pol_buf_q;
        ctl_val_o[1]    = upd_q;
        ctl_val_o[BW-1] = (st_q == CH_ILK_WAIT) || (st_q == CH_ILK_ARMED);
    end

    assign duty_act_o = duty_act_q;
    assign per_buf_o  = per_buf_q;
    assign per_act_o  = per_act_q;
    assign pwm_o      = pwm_q;

    // R3
    held_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == CH_ILK_WAIT) && !ctl_acc && !duty_wr) |=> $stable(duty_act_q));
    // R4
    immediate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_wr && !duty_held && upd_q && !lock) |=> (duty_act_q == $past(wdata[CW-1:0])));
    // R5
    period_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(per_act_q) |-> $past(cyc_end || preset));
    // R11
    polarity_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pol_act_q) |-> $past(cyc_end));
    // R9
    preset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_dual.sv
module pwm_dual
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              pwm_a,
    output logic              pwm_b
);
    logic [NCH-1:0]             duty_wr, ctl_wr, ctl_acc, end_w, wait_w, pwm_w;
    logic                       duty_held, per_wr, preset, lock;
    logic [NCH-1:0][DUTY_W-1:0] duty_act_w;
    logic [NCH-1:0][BUS_W-1:0]  ctl_val_w;
    logic [NCH-1:0][PER_W-1:0]  per_buf_w, per_act_w;

    assign lock = (per_act_w[0] == per_act_w[1]);

    pwm_regif u_regif (
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .duty_act  (duty_act_w),
        .ctl_val   (ctl_val_w),
        .per_val   (per_buf_w),
        .duty_wr   (duty_wr),
        .duty_held (duty_held),
        .ctl_wr    (ctl_wr),
        .ctl_acc   (ctl_acc),
        .per_wr    (per_wr),
        .preset    (preset),
        .rdata     (bus_rdata)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pwm_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .duty_wr    (duty_wr[ch]),
            .duty_held  (duty_held),
            .ctl_wr     (ctl_wr[ch]),
            .ctl_acc    (ctl_acc[ch]),
            .wdata      (bus_wdata),
            .per_wr     (per_wr),
            .per_wdata  (bus_wdata[ch*PER_W +: PER_W]),
            .preset     (preset),
            .lock       (lock),
            .peer_end   (end_w[1-ch]),
            .peer_wait  (wait_w[1-ch]),
            .end_o      (end_w[ch]),
            .wait_o     (wait_w[ch]),
            .duty_act_o (duty_act_w[ch]),
            .ctl_val_o  (ctl_val_w[ch]),
            .per_buf_o  (per_buf_w[ch]),
            .per_act_o  (per_act_w[ch]),
            .pwm_o      (pwm_w[ch])
        );
    end

    assign pwm_a = pwm_w[0];
    assign pwm_b = pwm_w[1];

    // R7
    lock_hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wait_w[0]) |=> $stable(duty_act_w[1]));
    // R7
    lock_hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && wait_w[1]) |=> $stable(duty_act_w[0]));
endmodule

// File: tb/tb_pwm_dual.sv
module tb_pwm_dual;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pwm_a, pwm_b;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pwm_dual dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic highs(input int n, input bit chb, output int h);
        h = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            h += chb ? int'(pwm_b) : int'(pwm_a);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int h, lo, falls, L, e;
        int rises[3];
        int nr;
        bit prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        h = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            h += int'(pwm_a) + int'(pwm_b);
        end
        chk("R10 outputs low", h, 0);
        rd(8'h10, v); chk("R10 duty A", v, 0);
        rd(8'h12, v); chk("R10 duty B", v, 0);
        rd(8'h14, v); chk("R10 ctl A", v, 0);

        // R1: period register read-back
        wr(8'h16, 8'hF0);
        rd(8'h16, v); chk("R1 period readback", v, 8'hF0);

        // R8: sweep of periods, duties and polarity (unlocked, B field 15)
        for (int f = 0; f < 3; f++) begin
            int dl[6];
            L = (f + 1) * 16;
            dl = '{0, 1, 7, L - 1, L, 255};
            for (int i = 0; i < 6; i++) begin
                wr(8'h14, 8'h02);
                wr(8'h16, 8'hF0 | 8'(f));
                wr(8'h17, 8'h00);
                wr(8'h10, 8'(dl[i]));
                repeat (L + 2) @(negedge clk);
                e = (dl[i] < L) ? dl[i] : L;
                highs(L, 1'b0, h); chk("R8 high count pol0", h, e);
                wr(8'h14, 8'h03);
                repeat (L + 2) @(negedge clk);
                highs(L, 1'b0, h); chk("R8 high count pol1", h, L - e);
            end
        end

        // R4 immediate, R2 read aliases, R4 deferred
        wr(8'h16, 8'hF0); wr(8'h17, 8'h00);
        wr(8'h14, 8'h02);
        wr(8'h10, 8'd3);
        rd(8'h10, v); chk("R4 immediate", v, 3);
        wr(8'h14, 8'h00);
        wr(8'h10, 8'd9);
        rd(8'h10, v); chk("R2 plain alias old", v, 3);
        rd(8'h11, v); chk("R2 held alias old", v, 3);
        repeat (20) @(negedge clk);
        rd(8'h10, v); chk("R4 deferred plain", v, 9);
        rd(8'h11, v); chk("R2 held alias new", v, 9);

        // R3: held write waits for control access
        wr(8'h11, 8'd20);
        repeat (40) @(negedge clk);
        rd(8'h10, v); chk("R3 held not moved", v, 9);
        rd(8'h14, v); chk("R3 pending flag", v, 8'h80);
        repeat (20) @(negedge clk);
        rd(8'h10, v); chk("R3 moved after arm", v, 20);
        rd(8'h14, v); chk("R3 flag cleared", v, 0);

        // R3: arm in the last clock of a period transfers at that boundary
        wr(8'h17, 8'h00);
        wr(8'h11, 8'd33);
        repeat (14) @(negedge clk);
        rd(8'h14, v); chk("R3 flag at last clock", v, 8'h80);
        rd(8'h10, v); chk("R3 same-boundary transfer", v, 33);

        // R11/R8: duty 0 with polarity flip gives constant high, no glitch
        wr(8'h10, 8'd8);
        repeat (40) @(negedge clk);
        wr(8'h11, 8'd0);
        wr(8'h14, 8'h01);
        falls = 0; lo = 0; prev = pwm_a;
        for (int k = 0; k < 48; k++) begin
            @(negedge clk);
            if (prev && !pwm_a) falls++;
            if (k >= 16 && !pwm_a) lo++;
            prev = pwm_a;
        end
        chk("R11 single fall at most", (falls <= 1) ? 1 : 0, 1);
        chk("R8 constant high tail", lo, 0);

        // R5: period change mid-cycle
        wr(8'h14, 8'h02);
        wr(8'h10, 8'd1);
        wr(8'h16, 8'hF0);
        wr(8'h17, 8'h00);
        nr = 0; prev = 1'b1;
        fork
            begin
                repeat (5) @(negedge clk);
                wr(8'h16, 8'hF1);
            end
            begin
                for (int k = 1; k <= 90; k++) begin
                    @(negedge clk);
                    if (k >= 2 && !prev && pwm_a && nr < 3) begin
                        rises[nr] = k; nr++;
                    end
                    prev = pwm_a;
                end
            end
        join
        chk("R5 running cycle kept", rises[0], 17);
        chk("R5 new period length", rises[1] - rises[0], 32);
        chk("R5 later period length", rises[2] - rises[1], 32);

        // R6: different periods, channels independent
        wr(8'h14, 8'h00);
        wr(8'h16, 8'h10); wr(8'h17, 8'h00);
        wr(8'h11, 8'd44);
        wr(8'h15, 8'h02);
        wr(8'h12, 8'd55);
        rd(8'h12, v); chk("R6 immediate B unlocked", v, 55);
        wr(8'h15, 8'h00);
        wr(8'h12, 8'd66);
        repeat (80) @(negedge clk);
        rd(8'h12, v); chk("R6 B moves while A waits", v, 66);
        rd(8'h10, v); chk("R6 A still held", v, 1);
        rd(8'h14, v);
        repeat (40) @(negedge clk);
        rd(8'h10, v); chk("R6 A after arm", v, 44);

        // R7: equal periods lockstep
        wr(8'h16, 8'h00); wr(8'h17, 8'h00);
        wr(8'h11, 8'd70);
        wr(8'h15, 8'h02);
        wr(8'h12, 8'd71);
        rd(8'h12, v); chk("R7 immediate ignored", v, 66);
        repeat (60) @(negedge clk);
        rd(8'h12, v); chk("R7 B held by A wait", v, 66);
        rd(8'h14, v);
        repeat (40) @(negedge clk);
        rd(8'h10, v); chk("R7 A after shared boundary", v, 70);
        rd(8'h12, v); chk("R7 B after shared boundary", v, 71);

        // R9: preset puts equal channels in phase
        wr(8'h14, 8'h00); wr(8'h15, 8'h00);
        wr(8'h16, 8'h33);
        wr(8'h10, 8'd5); wr(8'h12, 8'd5);
        repeat (200) @(negedge clk);
        wr(8'h17, 8'h00);
        lo = 0; h = 0;
        for (int k = 1; k <= 128; k++) begin
            @(negedge clk);
            if (pwm_a != pwm_b) lo++;
            if (k <= 64) h += int'(pwm_a);
        end
        chk("R9 outputs identical", lo, 0);
        chk("R9 high count after preset", h, 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule